// File: doc/BRIEF.md
# Test Access Port Controller

This block is a boundary-scan style test access port for a chip's test and debug logic. A sixteen-state controller advances on every rising edge of the test clock, steered by the mode-select input. It owns a 4-bit instruction register, a 1-bit bypass register and a 32-bit identification register. The serial output is taken from whichever of these shift paths is active.

An enable input stands in for the configuration bit that switches the port on. While the enable is low, the controller is forced into its reset state. There is no dedicated test-reset pin. The controller returns to reset only through the asynchronous power-on reset, five clocks with mode-select high, or the enable input.

External data registers attach through decoded strobes for the capture, shift and update states, a flag for the idle state and a flag for the reset state, and the latched instruction. One instruction code routes an external serial return line to the data output.

Top module: `tap_port`

## Requirements
- R1: The controller has 16 states. Each rising edge of `tck` moves it along the standard boundary-scan state graph according to `tms`. From the idle state, `tms` 1,1,0,0 reaches instruction shift and 1,0,0 reaches data shift. From either shift state, 1,1,0 returns to idle.
- R2: After `rst_n` is asserted, the controller is in the reset state. Five consecutive rising edges with `tms` high reach the reset state from any state.
- R3: While `port_en` is low, each rising edge puts the controller in the reset state, whatever `tms` is.
- R4: Every shift path shifts least significant bit first, with `tdi` sampled on the rising edge. The edge that leaves a shift state with `tms` high still shifts in one bit, which is the MSB.
- R5: In the instruction capture state, the instruction shifter loads 4'b0001. Those bits appear on `tdo`, LSB first, while the new instruction is shifted in.
- R6: `instr_out` changes only on the edge that leaves the instruction update state, when it takes the shifted value. On an edge taken in the reset state, it loads the identification code 4'hE.
- R7: With instruction 4'hE, data capture loads the 32-bit identification value, whose bit 0 is always 1. That value then shifts out on `tdo`.
- R8: Instruction 4'hF, and every code other than 4'hE and 4'h8, selects the 1-bit bypass register. Bypass captures 0 and delays `tdi` by one shift.
- R9: With instruction 4'h8, `tdo` in the data shift state follows `ext_tdo`.
- R10: `tdo` changes only on the falling edge of `tck`. Outside the two shift states it is held at 1.
- R11: `tlr`, `run_idle`, `capture_dr`, `shift_dr` and `update_dr` are each high exactly while the controller is in the matching state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| port_en | input | 1 | Port enable; low holds the controller in reset |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| ext_tdo | input | 1 | Serial return from an external data register |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| instr_out | output | 4 | Latched instruction |
| tlr | output | 1 | Controller is in the reset state |
| run_idle | output | 1 | Controller is in the idle state |
| capture_dr | output | 1 | Controller is in the data capture state |
| shift_dr | output | 1 | Controller is in the data shift state |
| update_dr | output | 1 | Controller is in the data update state |

## Verification
The state strobes, `instr_out` and the shift registers settle one rising edge after the `tms`/`tdi` values that cause them. `tdo` follows half a period later, at the next falling edge. After `rst_n` is released, the synchronizer passes two rising edges before the controller can leave reset. The bench drives inputs just after a falling edge and compares every decoded output and `tdo` just after the following falling edge against a reference model. Just after each rising edge, it also confirms that `tdo` still carries its previous value, which tests the falling-edge timing directly.

// File: rtl/tap_pkg.sv
package tap_pkg;

  typedef enum logic [3:0] {
    ST_TLR    = 4'd0,
    ST_RTI    = 4'd1,
    ST_SEL_DR = 4'd2,
    ST_CAP_DR = 4'd3,
    ST_SH_DR  = 4'd4,
    ST_EX1_DR = 4'd5,
    ST_PA_DR  = 4'd6,
    ST_EX2_DR = 4'd7,
    ST_UPD_DR = 4'd8,
    ST_SEL_IR = 4'd9,
    ST_CAP_IR = 4'd10,
    ST_SH_IR  = 4'd11,
    ST_EX1_IR = 4'd12,
    ST_PA_IR  = 4'd13,
    ST_EX2_IR = 4'd14,
    ST_UPD_IR = 4'd15
  } tap_state_e;

  // successor in the scan state graph for a given mode-select bit
  function automatic tap_state_e tap_next(input tap_state_e cur, input logic m);
    tap_state_e n;
    case (cur)
      ST_TLR:    n = m ? ST_TLR    : ST_RTI;
      ST_RTI:    n = m ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: n = m ? ST_UPD_DR : ST_PA_DR;
      ST_PA_DR:  n = m ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: n = m ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: n = m ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: n = m ? ST_UPD_IR : ST_PA_IR;
      ST_PA_IR:  n = m ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: n = m ? ST_SEL_DR : ST_RTI;
      default:   n = ST_TLR;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       port_en,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e state_d;

  always_comb begin
    if (!port_en) state_d = ST_TLR;
    else          state_d = tap_next(state, tms);
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= ST_TLR;
    else        state <= state_d;
  end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
#(
  parameter int              IR_W       = 4,
  parameter logic [IR_W-1:0] IR_CAPTURE = 1,
  parameter logic [IR_W-1:0] IR_RESET   = '1
) (
  input  logic            tck,
  input  logic            rst_n,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic [IR_W-1:0] instr,
  output logic            sr_lsb
);

  logic [IR_W-1:0] sr_q, sr_d;
  logic            sr_en;
  logic [IR_W-1:0] instr_d;
  logic            instr_en;

  always_comb begin
    sr_en = 1'b0;
    sr_d  = sr_q;
    if (state == ST_CAP_IR) begin
      sr_en = 1'b1;
      sr_d  = IR_CAPTURE;
    end else if (state == ST_SH_IR) begin
      sr_en = 1'b1;
      sr_d  = {tdi, sr_q[IR_W-1:1]};
    end
  end

  always_comb begin
    instr_en = 1'b0;
    instr_d  = instr;
    if (state == ST_TLR) begin
      instr_en = 1'b1;
      instr_d  = IR_RESET;
    end else if (state == ST_UPD_IR) begin
      instr_en = 1'b1;
      instr_d  = sr_q;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)        instr <= IR_RESET;
    else if (instr_en) instr <= instr_d;
  end

  assign sr_lsb = sr_q[0];

endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import tap_pkg::*;
#(
  parameter int              IR_W         = 4,
  parameter int              ID_W         = 32,
  parameter logic [ID_W-1:0] ID_VALUE     = 32'h1A5C_703F,
  parameter logic [IR_W-1:0] INSTR_IDCODE = 4'hE,
  parameter logic [IR_W-1:0] INSTR_EXT    = 4'h8
) (
  input  logic            tck,
  input  logic            rst_n,
  input  tap_state_e      state,
  input  logic [IR_W-1:0] instr,
  input  logic            tdi,
  input  logic            ext_tdo,
  output logic            dr_lsb
);

  localparam logic [ID_W-1:0] ID_CAPTURE = {ID_VALUE[ID_W-1:1], 1'b1};

  logic sel_id, sel_ext, sel_bp;
  logic cap_en, sh_en;

  assign sel_id  = (instr == INSTR_IDCODE);
  assign sel_ext = (instr == INSTR_EXT);
  assign sel_bp  = !sel_id && !sel_ext;
  assign cap_en  = (state == ST_CAP_DR);
  assign sh_en   = (state == ST_SH_DR);

  logic            bp_q, bp_d, bp_en;
  logic [ID_W-1:0] id_q, id_d;
  logic            id_en;

  always_comb begin
    bp_en = sel_bp && (cap_en || sh_en);
    bp_d  = cap_en ? 1'b0 : tdi;
    id_en = sel_id && (cap_en || sh_en);
    id_d  = cap_en ? ID_CAPTURE : {tdi, id_q[ID_W-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     bp_q <= 1'b0;
    else if (bp_en) bp_q <= bp_d;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     id_q <= '0;
    else if (id_en) id_q <= id_d;
  end

  always_comb begin
    if (sel_id)       dr_lsb = id_q[0];
    else if (sel_ext) dr_lsb = ext_tdo;
    else              dr_lsb = bp_q;
  end

endmodule

// File: rtl/tap_port.sv
module tap_port
  import tap_pkg::*;
#(
  parameter int              IR_W         = 4,
  parameter int              ID_W         = 32,
  parameter logic [ID_W-1:0] ID_VALUE     = 32'h1A5C_703F,
  parameter logic [IR_W-1:0] IR_CAPTURE   = 4'h1,
  parameter logic [IR_W-1:0] INSTR_IDCODE = 4'hE,
  parameter logic [IR_W-1:0] INSTR_EXT    = 4'h8,
  parameter logic            TDO_IDLE     = 1'b1
) (
  input  logic            tck,
  input  logic            rst_n,
  input  logic            port_en,
  input  logic            tms,
  input  logic            tdi,
  input  logic            ext_tdo,
  output logic            tdo,
  output logic [IR_W-1:0] instr_out,
  output logic            tlr,
  output logic            run_idle,
  output logic            capture_dr,
  output logic            shift_dr,
  output logic            update_dr
);

  // reset: asserted asynchronously, released on the second rising edge
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  tap_state_e state;
  logic       ir_lsb;
  logic       dr_lsb;

  tap_fsm u_fsm (
    .tck     (tck),
    .rst_n   (rst_sync_n),
    .port_en (port_en),
    .tms     (tms),
    .state   (state)
  );

  tap_ir #(
    .IR_W       (IR_W),
    .IR_CAPTURE (IR_CAPTURE),
    .IR_RESET   (INSTR_IDCODE)
  ) u_ir (
    .tck    (tck),
    .rst_n  (rst_sync_n),
    .state  (state),
    .tdi    (tdi),
    .instr  (instr_out),
    .sr_lsb (ir_lsb)
  );

  tap_dr #(
    .IR_W         (IR_W),
    .ID_W         (ID_W),
    .ID_VALUE     (ID_VALUE),
    .INSTR_IDCODE (INSTR_IDCODE),
    .INSTR_EXT    (INSTR_EXT)
  ) u_dr (
    .tck     (tck),
    .rst_n   (rst_sync_n),
    .state   (state),
    .instr   (instr_out),
    .tdi     (tdi),
    .ext_tdo (ext_tdo),
    .dr_lsb  (dr_lsb)
  );

  // serial output: selected per state, retimed to the falling edge
  logic tdo_d;

  always_comb begin
    case (state)
      ST_SH_IR: tdo_d = ir_lsb;
      ST_SH_DR: tdo_d = dr_lsb;
      default:  tdo_d = TDO_IDLE;
    endcase
  end

  always_ff @(negedge tck or negedge rst_sync_n) begin
    if (!rst_sync_n) tdo <= TDO_IDLE;
    else             tdo <= tdo_d;
  end

  assign tlr        = (state == ST_TLR);
  assign run_idle   = (state == ST_RTI);
  assign capture_dr = (state == ST_CAP_DR);
  assign shift_dr   = (state == ST_SH_DR);
  assign update_dr  = (state == ST_UPD_DR);

endmodule

// File: rtl/tap_port_checker.sv
module tap_port_checker
  import tap_pkg::*;
#(
  parameter int              IR_W         = 4,
  parameter logic [IR_W-1:0] INSTR_IDCODE = 4'hE,
  parameter logic            TDO_IDLE     = 1'b1
) (
  input logic            tck,
  input logic            rst_n,
  input logic            port_en,
  input logic            tms,
  input tap_state_e      state,
  input logic [IR_W-1:0] instr,
  input logic            tdo
);

  // run of rising edges with tms high, saturating at five
  logic [2:0] ones_cnt;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                   ones_cnt <= 3'd0;
    else if (!tms)                ones_cnt <= 3'd0;
    else if (ones_cnt != 3'd5)    ones_cnt <= ones_cnt + 3'd1;
  end

  // R2: five high mode-select edges land in reset
  a_r2_five_ones_reset: assert property (@(posedge tck) disable iff (!rst_n)
    (ones_cnt == 3'd5) |-> (state == ST_TLR));

  // R3: disabled port forces reset
  a_r3_disabled_holds_reset: assert property (@(posedge tck) disable iff (!rst_n)
    !port_en |=> (state == ST_TLR));

  // R1: capture followed by tms low enters shift
  a_r1_capture_to_shift: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_CAP_DR && !tms && port_en) |=> (state == ST_SH_DR));

  // R6: instruction output moves only out of update-IR or reset
  a_r6_instr_hold: assert property (@(posedge tck) disable iff (!rst_n)
    (state != ST_UPD_IR && state != ST_TLR) |=> $stable(instr));

  // R6: reset state restores the identification instruction
  a_r6_reset_idcode: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_TLR) |=> (instr == INSTR_IDCODE));

  // R10: serial output idles outside the shift states
  a_r10_tdo_idle: assert property (@(posedge tck) disable iff (!rst_n)
    (state != ST_SH_IR && state != ST_SH_DR) |-> (tdo == TDO_IDLE));

endmodule

bind tap_port tap_port_checker #(
  .IR_W         (IR_W),
  .INSTR_IDCODE (INSTR_IDCODE),
  .TDO_IDLE     (TDO_IDLE)
) u_chk (
  .tck     (tck),
  .rst_n   (rst_sync_n),
  .port_en (port_en),
  .tms     (tms),
  .state   (state),
  .instr   (instr_out),
  .tdo     (tdo)
);

// File: tb/tap_port_bench.sv
module tap_port_bench;

  localparam logic [31:0] ID_VAL = 32'h1A5C_703F;

  localparam int S_TLR = 0, S_RTI = 1, S_SDR = 2, S_CDR = 3, S_SHDR = 4,
                 S_E1DR = 5, S_PDR = 6, S_E2DR = 7, S_UDR = 8, S_SIR = 9,
                 S_CIR = 10, S_SHIR = 11, S_E1IR = 12, S_PIR = 13,
                 S_E2IR = 14, S_UIR = 15;

  logic       tck = 1'b0;
  logic       rst_n, port_en, tms, tdi, ext_tdo;
  logic       tdo;
  logic [3:0] instr_out;
  logic       tlr, run_idle, capture_dr, shift_dr, update_dr;

  tap_port u_tap_port (
    .tck        (tck),
    .rst_n      (rst_n),
    .port_en    (port_en),
    .tms        (tms),
    .tdi        (tdi),
    .ext_tdo    (ext_tdo),
    .tdo        (tdo),
    .instr_out  (instr_out),
    .tlr        (tlr),
    .run_idle   (run_idle),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .update_dr  (update_dr)
  );

  always #10 tck = ~tck;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  // reference model
  int          m_st;
  logic [3:0]  m_ir_sr, m_instr;
  logic        m_bp;
  logic [31:0] m_id;
  logic        exp_tdo;

  function automatic int nxt(input int s, input logic m);
    case (s)
      S_TLR:  return m ? S_TLR  : S_RTI;
      S_RTI:  return m ? S_SDR  : S_RTI;
      S_SDR:  return m ? S_SIR  : S_CDR;
      S_CDR:  return m ? S_E1DR : S_SHDR;
      S_SHDR: return m ? S_E1DR : S_SHDR;
      S_E1DR: return m ? S_UDR  : S_PDR;
      S_PDR:  return m ? S_E2DR : S_PDR;
      S_E2DR: return m ? S_UDR  : S_SHDR;
      S_UDR:  return m ? S_SDR  : S_RTI;
      S_SIR:  return m ? S_TLR  : S_CIR;
      S_CIR:  return m ? S_E1IR : S_SHIR;
      S_SHIR: return m ? S_E1IR : S_SHIR;
      S_E1IR: return m ? S_UIR  : S_PIR;
      S_PIR:  return m ? S_E2IR : S_PIR;
      S_E2IR: return m ? S_UIR  : S_SHIR;
      default: return m ? S_SDR : S_RTI;
    endcase
  endfunction

  function automatic logic [4:0] exp_strobes(input int s);
    return {s == S_TLR, s == S_RTI, s == S_CDR, s == S_SHDR, s == S_UDR};
  endfunction

  function automatic logic model_tdo();
    if (m_st == S_SHIR) return m_ir_sr[0];
    if (m_st == S_SHDR) begin
      if (m_instr == 4'hE) return m_id[0];
      if (m_instr == 4'h8) return ext_tdo;
      return m_bp;
    end
    return 1'b1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    int s = m_st;
    if (s == S_CIR)       m_ir_sr = 4'b0001;
    else if (s == S_SHIR) m_ir_sr = {tdi, m_ir_sr[3:1]};
    if (s == S_TLR)       m_instr = 4'hE;
    else if (s == S_UIR)  m_instr = m_ir_sr;
    if (s == S_CDR) begin
      m_bp = 1'b0;
      m_id = {ID_VAL[31:1], 1'b1};
    end else if (s == S_SHDR) begin
      m_bp = tdi;
      m_id = {tdi, m_id[31:1]};
    end
    m_st = port_en ? nxt(s, tms) : S_TLR;
  endtask

  // one clock: drive after a falling edge, compare after the next one
  task automatic tick(input logic tms_v, input logic tdi_v);
    tms = tms_v;
    tdi = tdi_v;
    @(posedge tck);
    #2;
    chk(tdo === exp_tdo, "R10 tdo held until falling edge", {31'd0, tdo}, {31'd0, exp_tdo});
    model_edge();
    @(negedge tck);
    #2;
    exp_tdo = model_tdo();
    chk({tlr, run_idle, capture_dr, shift_dr, update_dr} === exp_strobes(m_st),
        "R1/R11 state strobes",
        {27'd0, tlr, run_idle, capture_dr, shift_dr, update_dr}, {27'd0, exp_strobes(m_st)});
    chk(instr_out === m_instr, "R6 instruction output", {28'd0, instr_out}, {28'd0, m_instr});
    chk(tdo === exp_tdo, "R4/R10 serial output", {31'd0, tdo}, {31'd0, exp_tdo});
  endtask

  // from idle: load an instruction, returning what was shifted out
  task automatic load_ir(input logic [3:0] val, output logic [3:0] cap);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 4; i++) begin
      cap[i] = tdo;
      tick(i == 3, val[i]);
    end
    tick(1, 0);
    tick(0, 0);
  endtask

  // from idle: scan n data bits
  task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
    dout = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      tick(i == n - 1, din[i]);
    end
    tick(1, 0);
    tick(0, 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [3:0]  cap;
    logic [31:0] dout;
    logic [31:0] pat;
    int unsigned seed;
    seed = 32'd1149;
    void'($urandom(seed));

    rst_n = 1'b0; port_en = 1'b1; tms = 1'b1; tdi = 1'b0; ext_tdo = 1'b0;
    m_st = S_TLR; m_ir_sr = '0; m_instr = 4'hE; m_bp = 1'b0; m_id = '0; exp_tdo = 1'b1;
    repeat (3) @(negedge tck);
    #2;
    // R2 reset state
    chk(tlr === 1'b1, "R2 reset state", {31'd0, tlr}, 32'd1);
    chk(tdo === 1'b1, "R10 idle tdo in reset", {31'd0, tdo}, 32'd1);
    chk(instr_out === 4'hE, "R6 reset instruction", {28'd0, instr_out}, 32'hE);
    chk({run_idle, capture_dr, shift_dr, update_dr} === 4'b0, "R11 strobes low",
        {28'd0, run_idle, capture_dr, shift_dr, update_dr}, 32'd0);
    rst_n = 1'b1;
    repeat (3) tick(1, 1);
    tick(0, 0);
    chk(run_idle === 1'b1, "R1 idle reached", {31'd0, run_idle}, 32'd1);

    // R7 identification read after reset
    scan_dr(32, 32'hFFFF_0000, dout);
    chk(dout === {ID_VAL[31:1], 1'b1}, "R7 id value", dout, {ID_VAL[31:1], 1'b1});
    chk(dout[0] === 1'b1, "R7 id bit0", {31'd0, dout[0]}, 32'd1);

    // R5 capture 0001, R8 bypass
    load_ir(4'hF, cap);
    chk(cap === 4'b0001, "R5 ir capture", {28'd0, cap}, 32'd1);
    chk(instr_out === 4'hF, "R6 instruction after update", {28'd0, instr_out}, 32'hF);
    pat = 32'h0000_00B5;
    scan_dr(8, pat, dout);
    chk(dout[7:0] === {pat[6:0], 1'b0}, "R8 bypass delay", {24'd0, dout[7:0]}, {24'd0, pat[6:0], 1'b0});

    // R8 unassigned code selects bypass; R4 LSB-first loaded code
    load_ir(4'h3, cap);
    chk(instr_out === 4'h3, "R4 instruction lsb first", {28'd0, instr_out}, 32'h3);
    pat = 32'h0000_0036;
    scan_dr(6, pat, dout);
    chk(dout[5:0] === {pat[4:0], 1'b0}, "R8 unassigned bypass", {26'd0, dout[5:0]}, {26'd0, pat[4:0], 1'b0});

    // R9 external path
    load_ir(4'h8, cap);
    ext_tdo = 1'b1;
    tick(1, 0); tick(0, 0); tick(0, 0);
    chk(tdo === 1'b1, "R9 ext high", {31'd0, tdo}, 32'd1);
    ext_tdo = 1'b0;
    tick(0, 0);
    chk(tdo === 1'b0, "R9 ext low", {31'd0, tdo}, 32'd0);

    // R3 disable from within shift
    port_en = 1'b0;
    tick(0, 0);
    chk(tlr === 1'b1, "R3 disable forces reset", {31'd0, tlr}, 32'd1);
    tick(0, 1);
    chk(tlr === 1'b1, "R3 reset held", {31'd0, tlr}, 32'd1);
    port_en = 1'b1;
    tick(0, 0);

    // random walk against the model
    for (int i = 0; i < 4000; i++) begin
      ext_tdo = 1'($urandom);
      port_en = ($urandom % 64) != 0;
      tick(1'($urandom), 1'($urandom));
      if (i % 500 == 499) begin
        port_en = 1'b1;
        repeat (5) tick(1, 1'($urandom));
        chk(tlr === 1'b1, "R2 five ones reach reset", {31'd0, tlr}, 32'd1);
        tick(0, 0);
      end
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule